// File: doc/BRIEF.md
# Card Clock Generator with Shared Divider Bank

This block produces the card clocks for two card slots from one input clock. It has a bank of four programmable dividers that run side by side. Each slot routes one divider to its output. Each slot can also be switched off, or put into a low-power mode that stops its clock while the card reports idle. Each card clock is given as a level output plus an edge-enable output. The edge enable is high in the first input-clock cycle of every high phase. Both outputs are registered in the input-clock domain.

Software writes divider settings, source routing and gating bits into a shadow set. Those writes do not change the running clocks. The new values reach the working set only when an update is requested. The block then holds every running slot at its next low phase and swaps in the whole shadow set at once. It restarts all dividers from the start of a low phase and answers with a one-cycle acknowledge. An update sends nothing to a card. The busy flag it raises drops by itself when the update has been served.

Top module: `card_clk_gen`

## Requirements
- R1: A divider with setting n from 1 to 255 gives a 50% duty waveform. The waveform is high for n input cycles and low for n input cycles, so the ratio is 2*n.
- R2: A setting of n = 0 bypasses the divider, giving ratio 1: the slot's level output stays high and its edge enable is high in every cycle. The largest setting, 255, gives a period of 510 cycles.
- R3: The source word (address 1) routes the dividers to the slots. Slot 0 uses bits [1:0] and slot 1 uses bits [3:2]. Code k selects divider k.
- R4: When a slot's working enable bit is 0, its level and edge-enable outputs stay low.
- R5: When a slot's working low-power bit is 1 and its idle input is high, its clock is stopped (low). The clock resumes when the idle input drops. Idle has no effect when low-power is 0.
- R6: Writes change only the shadow set, and the outputs keep their old behaviour until an update is served. Address 0 holds divider k's setting in bits [8k+7:8k]. Address 1 holds the source word. Address 2 holds the per-slot enables in bits [1:0] and the per-slot low-power bits in bits [3:2].
- R7: An update request sets the busy output. Busy stays set until both slots are stopped and the shadow set has been loaded. A request made while busy is ignored. Busy is low in the cycle the acknowledge is high.
- R8: Each served request gives exactly one acknowledge pulse, one input cycle wide. The pulse comes in the cycle after the new values are loaded.
- R9: A slot's clock starts and stops only while its selected divider is low, or while that divider is in bypass. It changes source only while stopped. Every high phase seen at the output is therefore full width, and a new setting starts with a low phase.
- R10: After reset all dividers are in bypass and both slots are disabled. Both clock outputs, busy and acknowledge are low.
- R11: A slot's edge enable is high only in the first cycle of each high phase of its level output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock for the dividers and the registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the shadow set |
| cfg_addr | input | 2 | Shadow word select: 0 dividers, 1 source, 2 gating |
| cfg_wdata | input | 32 | Write data |
| upd_req | input | 1 | Request to copy the shadow set into the working set |
| slot_idle | input | 2 | Per-slot card idle indication |
| upd_busy | output | 1 | Update requested and not yet served |
| upd_ack | output | 1 | One-cycle pulse after the working set was loaded |
| slot_clk | output | 2 | Per-slot card clock level |
| slot_ce | output | 2 | Per-slot edge enable, high in the first high cycle |

## Verification
The bench measures the high and low widths of each slot clock for settings of 1, 2, 3 and 255, and for the bypass case. A divider off by one or with an odd split would show up there as a wrong width. Every high pulse is compared against the width expected for the current configuration. These checks cover update swaps, low-power stops and restarts. A design that gated or switched sources in the middle of a high phase would show a short runt pulse. A design that applied writes directly would change the clocks before the acknowledge. The bench also repeats a request while busy and counts the acknowledges. A design that served the repeat would produce a second acknowledge that no queued expectation accounts for.

// File: rtl/ccg_pkg.sv
package ccg_pkg;

  typedef enum logic [1:0] {
    CCG_REG_DIV  = 2'd0,
    CCG_REG_SRC  = 2'd1,
    CCG_REG_GATE = 2'd2
  } ccg_reg_e;

  // A setting of zero passes the input clock straight through.
  function automatic logic ccg_is_bypass(input int unsigned n);
    return n == 0;
  endfunction

  // Last count value of a half period before the level flips.
  function automatic int unsigned ccg_last_count(input int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

  // Full divide ratio for a setting.
  function automatic int unsigned ccg_ratio(input int unsigned n);
    return (n == 0) ? 1 : 2 * n;
  endfunction

endpackage

// File: rtl/ccg_shadow.sv
module ccg_shadow
  import ccg_pkg::*;
#(
  parameter int NUM_DIVS  = 4,
  parameter int NUM_SLOTS = 2,
  parameter int DIV_W     = 8,
  parameter int DATA_W    = 32,
  localparam int SEL_W    = (NUM_DIVS > 1) ? $clog2(NUM_DIVS) : 1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cfg_we,
  input  logic [1:0]                          cfg_addr,
  input  logic [DATA_W-1:0]                   cfg_wdata,
  output logic [NUM_DIVS-1:0][DIV_W-1:0]      div_n_sh,
  output logic [NUM_SLOTS-1:0][SEL_W-1:0]     src_sh,
  output logic [NUM_SLOTS-1:0]                en_sh,
  output logic [NUM_SLOTS-1:0]                lp_sh
);

  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata;

  logic wr_div, wr_src, wr_gate;
  assign wr_div  = cfg_we && (cfg_addr == CCG_REG_DIV);
  assign wr_src  = cfg_we && (cfg_addr == CCG_REG_SRC);
  assign wr_gate = cfg_we && (cfg_addr == CCG_REG_GATE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_n_sh <= '0;
      src_sh   <= '0;
      en_sh    <= '0;
      lp_sh    <= '0;
    end else begin
      if (wr_div) begin
        for (int k = 0; k < NUM_DIVS; k++) begin
          div_n_sh[k] <= cfg_wdata[k*DIV_W +: DIV_W];
        end
      end
      if (wr_src) begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
          src_sh[s] <= cfg_wdata[s*SEL_W +: SEL_W];
        end
      end
      if (wr_gate) begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
          en_sh[s] <= cfg_wdata[s];
          lp_sh[s] <= cfg_wdata[NUM_SLOTS + s];
        end
      end
    end
  end

endmodule

// File: rtl/ccg_divider.sv
module ccg_divider
  import ccg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic [DIV_W-1:0] n_new,
  output logic             lvl,
  output logic             rise,
  output logic             byp
);

  logic [DIV_W-1:0] n_q;
  logic [DIV_W-1:0] cnt_q;
  logic             lvl_q;
  logic             lvl_d;
  logic             at_last;

  assign byp     = ccg_is_bypass(32'(n_q));
  assign at_last = (cnt_q == DIV_W'(ccg_last_count(32'(n_q))));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q   <= '0;
      cnt_q <= '0;
      lvl_q <= 1'b1;
      lvl_d <= 1'b1;
    end else begin
      lvl_d <= lvl_q;
      if (reload) begin
        n_q   <= n_new;
        cnt_q <= '0;
        lvl_q <= ccg_is_bypass(32'(n_new));
      end else if (byp) begin
        cnt_q <= '0;
        lvl_q <= 1'b1;
      end else if (at_last) begin
        cnt_q <= '0;
        lvl_q <= ~lvl_q;
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end
  end

  assign lvl  = lvl_q;
  assign rise = byp | (lvl_q & ~lvl_d);

  // R1
  div_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (n_q != '0) |-> (cnt_q < n_q));

  // R1
  div_half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && n_q != '0 && cnt_q != n_q - DIV_W'(1)) |=> $stable(lvl_q));

  // R2
  div_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && n_q == '0) |=> (lvl_q && n_q == '0));

endmodule

// File: rtl/ccg_slot.sv
module ccg_slot #(
  parameter int NUM_DIVS = 4,
  localparam int SEL_W   = (NUM_DIVS > 1) ? $clog2(NUM_DIVS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                hold,
  input  logic                idle,
  input  logic [SEL_W-1:0]    src_new,
  input  logic                en_new,
  input  logic                lp_new,
  input  logic [NUM_DIVS-1:0] div_lvl,
  input  logic [NUM_DIVS-1:0] div_rise,
  input  logic [NUM_DIVS-1:0] div_byp,
  output logic                clk_out,
  output logic                ce_out,
  output logic                parked
);

  logic [SEL_W-1:0] src_q;
  logic             en_q;
  logic             lp_q;
  logic             gate_q;
  logic             want;
  logic             safe;
  logic             sel_lvl;
  logic             sel_rise;
  logic             sel_byp;

  assign sel_lvl  = div_lvl[src_q];
  assign sel_rise = div_rise[src_q];
  assign sel_byp  = div_byp[src_q];

  assign want = en_q & ~(lp_q & idle) & ~hold;
  assign safe = sel_byp | ~sel_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      en_q   <= 1'b0;
      lp_q   <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      if (load) begin
        src_q <= src_new;
        en_q  <= en_new;
        lp_q  <= lp_new;
      end
      if ((want != gate_q) && safe) begin
        gate_q <= want;
      end
    end
  end

  assign clk_out = gate_q & sel_lvl;
  assign ce_out  = gate_q & sel_rise;
  assign parked  = ~gate_q;

  // R9
  gate_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gate_q) |-> $past(safe));

  // R9
  switch_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !gate_q);

  // R4
  gate_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_q && !want) |=> !gate_q);

endmodule

// File: rtl/ccg_update.sv
module ccg_update (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_req,
  input  logic parked_all,
  output logic load,
  output logic busy,
  output logic ack
);

  logic pending_q;
  logic ack_q;

  assign load = pending_q & parked_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      ack_q     <= 1'b0;
    end else begin
      ack_q <= load;
      if (load) begin
        pending_q <= 1'b0;
      end else if (upd_req) begin
        pending_q <= 1'b1;
      end
    end
  end

  assign busy = pending_q;
  assign ack  = ack_q;

  // R8
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);

  // R7
  ack_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> (!pending_q && $past(pending_q)));

  // R7
  busy_until_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !parked_all) |=> pending_q);

endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen #(
  parameter int NUM_DIVS  = 4,
  parameter int NUM_SLOTS = 2,
  parameter int DIV_W     = 8,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_addr,
  input  logic [DATA_W-1:0]    cfg_wdata,
  input  logic                 upd_req,
  input  logic [NUM_SLOTS-1:0] slot_idle,
  output logic                 upd_busy,
  output logic                 upd_ack,
  output logic [NUM_SLOTS-1:0] slot_clk,
  output logic [NUM_SLOTS-1:0] slot_ce
);

  localparam int SEL_W = (NUM_DIVS > 1) ? $clog2(NUM_DIVS) : 1;

  logic [NUM_DIVS-1:0][DIV_W-1:0]  div_n_sh;
  logic [NUM_SLOTS-1:0][SEL_W-1:0] src_sh;
  logic [NUM_SLOTS-1:0]            en_sh;
  logic [NUM_SLOTS-1:0]            lp_sh;

  logic [NUM_DIVS-1:0]  div_lvl;
  logic [NUM_DIVS-1:0]  div_rise;
  logic [NUM_DIVS-1:0]  div_byp;
  logic [NUM_SLOTS-1:0] slot_parked;
  logic                 parked_all;
  logic                 load;

  assign parked_all = &slot_parked;

  ccg_shadow #(
    .NUM_DIVS (NUM_DIVS),
    .NUM_SLOTS(NUM_SLOTS),
    .DIV_W    (DIV_W),
    .DATA_W   (DATA_W)
  ) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .div_n_sh (div_n_sh),
    .src_sh   (src_sh),
    .en_sh    (en_sh),
    .lp_sh    (lp_sh)
  );

  ccg_update u_update (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_req   (upd_req),
    .parked_all(parked_all),
    .load      (load),
    .busy      (upd_busy),
    .ack       (upd_ack)
  );

  for (genvar k = 0; k < NUM_DIVS; k++) begin : g_div
    ccg_divider #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .reload(load),
      .n_new (div_n_sh[k]),
      .lvl   (div_lvl[k]),
      .rise  (div_rise[k]),
      .byp   (div_byp[k])
    );
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    ccg_slot #(.NUM_DIVS(NUM_DIVS)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .hold    (upd_busy),
      .idle    (slot_idle[s]),
      .src_new (src_sh[s]),
      .en_new  (en_sh[s]),
      .lp_new  (lp_sh[s]),
      .div_lvl (div_lvl),
      .div_rise(div_rise),
      .div_byp (div_byp),
      .clk_out (slot_clk[s]),
      .ce_out  (slot_ce[s]),
      .parked  (slot_parked[s])
    );
  end

  // R11
  ce_with_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_ce & ~slot_clk) == '0));

  // R8
  ack_all_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_ack |-> parked_all);

endmodule

// File: tb/card_clk_gen_bench.sv
module card_clk_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        upd_req = 1'b0;
  logic [1:0]  slot_idle = '0;
  logic        upd_busy;
  logic        upd_ack;
  logic [1:0]  slot_clk;
  logic [1:0]  slot_ce;

  always #2 clk = ~clk;

  card_clk_gen u_card_clk_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .upd_req  (upd_req),
    .slot_idle(slot_idle),
    .upd_busy (upd_busy),
    .upd_ack  (upd_ack),
    .slot_clk (slot_clk),
    .slot_ce  (slot_ce)
  );

  typedef struct {
    int hi0;
    int hi1;
  } exp_t;

  exp_t exp_q[$];
  exp_t exp_pop;
  int   exp_hi[2];
  int   run_hi[2];
  int   n_cmp = 0;
  int   n_bad = 0;
  int   ack_cnt = 0;
  logic ack_prev = 1'b0;
  logic mon_on = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Monitor: pops the expected widths at each acknowledge and compares every
  // completed high pulse of each slot against them (R9).
  always @(negedge clk) begin
    if (mon_on) begin
      if (upd_ack) begin
        ack_cnt++;
        check(!ack_prev, "R8", "acknowledge width", 2, 1);
        check(!upd_busy, "R7", "busy during acknowledge", int'(upd_busy), 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "unexpected acknowledge", 1, 0);
        end else begin
          exp_pop   = exp_q.pop_front();
          exp_hi[0] = exp_pop.hi0;
          exp_hi[1] = exp_pop.hi1;
        end
      end
      ack_prev = upd_ack;
      for (int s = 0; s < 2; s++) begin
        if (slot_clk[s]) begin
          run_hi[s]++;
        end else begin
          if (run_hi[s] > 0 && exp_hi[s] > 0) begin
            check(run_hi[s] == exp_hi[s], "R9", $sformatf("slot%0d high pulse", s),
                  run_hi[s], exp_hi[s]);
          end
          run_hi[s] = 0;
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  // Driver: queues the widths expected after the acknowledge, then requests.
  task automatic update(input int h0, input int h1, input int req_cycles);
    exp_t e;
    int   t;
    e.hi0 = h0;
    e.hi1 = h1;
    exp_q.push_back(e);
    @(negedge clk);
    upd_req = 1'b1;
    repeat (req_cycles) @(negedge clk);
    upd_req = 1'b0;
    t = 0;
    while (upd_busy && t < 3000) begin
      @(negedge clk);
      t++;
    end
    check(!upd_busy, "R7", "busy cleared after service", int'(upd_busy), 0);
  endtask

  task automatic measure(input int s, input int hi, input int lo, input string req);
    int t;
    int h;
    int l;
    int ces;
    t = 0;
    while (!slot_ce[s] && t < 2000) begin
      @(negedge clk);
      t++;
    end
    check(slot_ce[s] == 1'b1, req, $sformatf("slot%0d edge enable seen", s), int'(slot_ce[s]), 1);
    check(slot_clk[s] == 1'b1, "R11", "level high with edge enable", int'(slot_clk[s]), 1);
    h = 0;
    ces = 0;
    while (slot_clk[s] && h < 2000) begin
      if (slot_ce[s]) ces++;
      h++;
      @(negedge clk);
    end
    l = 0;
    while (!slot_clk[s] && l < 2000) begin
      l++;
      @(negedge clk);
    end
    check(h == hi, req, $sformatf("slot%0d high cycles", s), h, hi);
    check(l == lo, req, $sformatf("slot%0d low cycles", s), l, lo);
    check(ces == 1, "R11", "edge enables per high phase", ces, 1);
  endtask

  task automatic watch_low(input int s, input int cycles, input string req);
    int hits;
    hits = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (slot_clk[s] || slot_ce[s]) hits++;
    end
    check(hits == 0, req, $sformatf("slot%0d active cycles while stopped", s), hits, 0);
  endtask

  task automatic watch_bypass(input int s, input int cycles);
    int miss;
    miss = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (!(slot_clk[s] && slot_ce[s])) miss++;
    end
    check(miss == 0, "R2", $sformatf("slot%0d bypass missing cycles", s), miss, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int acks_before;
    exp_hi[0] = 0;
    exp_hi[1] = 0;
    run_hi[0] = 0;
    run_hi[1] = 0;
    repeat (5) @(negedge clk);
    // R10: state during reset
    check(slot_clk == 2'b00, "R10", "clock outputs in reset", int'(slot_clk), 0);
    check(slot_ce == 2'b00, "R10", "edge enables in reset", int'(slot_ce), 0);
    check(!upd_busy && !upd_ack, "R10", "busy/ack in reset", int'({upd_busy, upd_ack}), 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);
    check(slot_clk == 2'b00, "R10", "clock outputs after reset", int'(slot_clk), 0);

    // R6: writes alone do not start the clocks
    wr(2'd0, 32'h0201_0300);
    wr(2'd1, 32'h0000_0009);
    wr(2'd2, 32'h0000_0003);
    watch_low(0, 20, "R6");
    watch_low(1, 20, "R6");

    // R1/R3: slot0 -> divider1 (n=3), slot1 -> divider2 (n=1)
    update(3, 1, 1);
    measure(0, 3, 3, "R1");
    measure(1, 1, 1, "R3");

    // R3/R2: slot0 -> divider0 (bypass), slot1 -> divider3 (n=2) via bits [3:2]
    wr(2'd1, 32'h0000_000C);
    update(0, 2, 1);
    measure(1, 2, 2, "R3");
    watch_bypass(0, 16);

    // R2: largest setting on divider1, period 510
    wr(2'd0, 32'h0201_FF00);
    wr(2'd1, 32'h0000_000D);
    update(255, 2, 1);
    measure(0, 255, 255, "R2");

    // R4: slot1 disabled
    wr(2'd2, 32'h0000_0001);
    update(255, 0, 1);
    watch_low(1, 40, "R4");

    // R5: low-power on slot0 only
    wr(2'd0, 32'h0201_0300);
    wr(2'd1, 32'h0000_0009);
    wr(2'd2, 32'h0000_0007);
    update(3, 1, 1);
    measure(0, 3, 3, "R1");
    repeat (2) @(negedge clk);
    slot_idle = 2'b11;
    repeat (8) @(negedge clk);
    watch_low(0, 30, "R5");
    measure(1, 1, 1, "R5");
    slot_idle = 2'b00;
    measure(0, 3, 3, "R5");

    // R7/R8: request held for two cycles yields one acknowledge
    acks_before = ack_cnt;
    update(3, 1, 2);
    repeat (30) @(negedge clk);
    check(ack_cnt - acks_before == 1, "R8", "acknowledges per request", ack_cnt - acks_before, 1);
    check(!upd_busy, "R7", "repeat request ignored", int'(upd_busy), 0);

    // R6: shadow write without update leaves slot0 unchanged
    wr(2'd0, 32'h0201_0500);
    measure(0, 3, 3, "R6");

    check(exp_q.size() == 0, "R8", "outstanding expected acknowledges", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule